// File: doc/BRIEF.md
# Receive ring page manager

This block keeps the bookkeeping for a circular receive area in a packet buffer RAM made of 256-byte pages. The area runs from a start page up to, but not including, a stop page. The receiver moves the write page pointer as it stores frames. The consumer side owns a boundary pointer that names the last page it has given back. The block reads the buffer through a synchronous read port with one cycle of latency.

A consumer pulses a poll request. The block first repairs corrupt or overflowed pointers. It then checks whether a frame is waiting. If one is, it fetches the frame's 4-byte header. The header holds a status byte, the next-page link and a 16-bit stored length that counts the header itself. The block then presents the payload length and start address. It streams payload bytes on request with wrap at the ring's end, and moves the boundary when the consumer releases the frame. Frames whose payload exceeds a programmed limit are released at once and flagged as dropped.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the boundary and write page read 0, the overflow flag is clear, and `frame_vld_o`, `none_o`, `drop_o` and `ram_re_o` are low.
- R2: `ovf_set_i` sets `ovf_o`. A poll while `ovf_o` is set makes boundary = start and write page = start+1, clears `ovf_o`, pulses `none_o` and issues no RAM read.
- R3: A poll while the boundary is below start or at or above stop makes boundary = start and write page = start+1, and pulses `none_o`.
- R4: The read page is boundary+1, replaced by start when that value is at or above stop. When the read page equals the write page, a poll pulses `none_o` one cycle later and issues no RAM read.
- R5: Otherwise the block reads byte addresses readpage*256+0..3: byte 0 is status, byte 1 is next page, byte 2 is length low and byte 3 is length high. `frame_vld_o` rises only after all four bytes are captured, 7 cycles after the poll is sampled.
- R6: A next page outside start..stop-1 pulses `none_o` and leaves the boundary unchanged.
- R7: While `frame_vld_o` is high, `pay_len_o` = stored length - 4 and `pay_addr_o` = readpage*256 + 4.
- R8: A payload longer than `max_len_i` pulses `drop_o`, never raises `frame_vld_o`, and updates the boundary as in R10.
- R9: `byte_rd_i` during a frame reads the current byte address. `rd_vld_o` and `rd_data_o` follow one cycle later. The address then advances by one, and on reaching stop*256 it drops by (stop-start)*256.
- R10: `release_i` during a frame sets the boundary to next page - 1, or to stop-1 when that falls below start, and lowers `frame_vld_o`.
- R11: `release_i` and `byte_rd_i` while no frame is presented have no effect: the boundary is unchanged and no RAM read is issued.
- R12: `cur_wr_i` loads `cur_pg_i` into the write page in any state, including the same cycle as a release, where both updates take effect. A pointer reset from R2 or R3 in the same cycle overrides it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pg_i | input | 8 | First page of the ring |
| stop_pg_i | input | 8 | Page just past the ring |
| max_len_i | input | 16 | Largest payload delivered |
| cur_wr_i | input | 1 | Load the write page |
| cur_pg_i | input | 8 | New write page value |
| ovf_set_i | input | 1 | Receiver overflow event |
| poll_i | input | 1 | Consumer asks for the next frame |
| release_i | input | 1 | Consumer gives the presented frame back |
| byte_rd_i | input | 1 | Read one payload byte |
| ram_re_o | output | 1 | Buffer read enable |
| ram_addr_o | output | 16 | Buffer byte address |
| ram_rdata_i | input | 8 | Buffer data, one cycle after the read |
| none_o | output | 1 | Pulse: poll ended without a frame |
| drop_o | output | 1 | Pulse: oversize frame discarded |
| frame_vld_o | output | 1 | A frame is presented |
| pay_len_o | output | 16 | Payload length |
| pay_addr_o | output | 16 | Payload start address |
| rd_vld_o | output | 1 | Payload byte valid |
| rd_data_o | output | 8 | Payload byte |
| bnry_o | output | 8 | Boundary page |
| curr_o | output | 8 | Write page |
| ovf_o | output | 1 | Overflow pending |

## Verification
The receiver's write-page update can land in the same cycle as a consumer action. The bench drives `cur_wr_i` together with `release_i` and expects both pointers to move. It also drives `cur_wr_i` together with a poll that finds overflow pending, and expects the pointer reset to win and the write page to read start+1. Wrap of the payload address across the stop page is checked on a frame stored in the last page.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_CHECK, ST_FRAME} ring_st_e;
  // header byte positions (the capture order depends on them)
  localparam int HDR_STAT  = 0;
  localparam int HDR_NEXT  = 1;
  localparam int HDR_LEN_L = 2;
  localparam int HDR_LEN_H = 3;
  localparam int HDR_BYTES = 4;
endpackage

// File: rtl/rx_ring_ptrs.sv
module rx_ring_ptrs #(
  parameter int PG_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PG_W-1:0] start_pg_i,
  input  logic [PG_W-1:0] stop_pg_i,
  input  logic            rst_ptr_i,
  input  logic            rel_i,
  input  logic [PG_W-1:0] rel_nxt_i,
  input  logic            cur_wr_i,
  input  logic [PG_W-1:0] cur_pg_i,
  input  logic            ovf_set_i,
  input  logic            ovf_clr_i,
  output logic [PG_W-1:0] bnry_o,
  output logic [PG_W-1:0] curr_o,
  output logic [PG_W-1:0] rd_pg_o,
  output logic            ovf_o,
  output logic            bnry_ok_o,
  output logic            empty_o
);
  logic [PG_W-1:0] bnry_q, curr_q, rel_bnry;
  logic [PG_W:0]   bnry_inc;
  logic            ovf_q;

  assign bnry_inc  = {1'b0, bnry_q} + 1'b1;
  assign rd_pg_o   = (bnry_inc >= {1'b0, stop_pg_i}) ? start_pg_i : bnry_inc[PG_W-1:0];
  assign bnry_ok_o = (bnry_q >= start_pg_i) && (bnry_q < stop_pg_i);
  assign empty_o   = (rd_pg_o == curr_q);
  // next-1 below start <=> next <= start
  assign rel_bnry  = (rel_nxt_i <= start_pg_i) ? stop_pg_i - 1'b1 : rel_nxt_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnry_q <= '0;
      curr_q <= '0;
    end else if (rst_ptr_i) begin
      bnry_q <= start_pg_i;
      curr_q <= start_pg_i + 1'b1;
    end else begin
      if (rel_i)    bnry_q <= rel_bnry;
      if (cur_wr_i) curr_q <= cur_pg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_set_i) ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign bnry_o = bnry_q;
  assign curr_o = curr_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/rx_hdr_capture.sv
module rx_hdr_capture #(
  parameter int N     = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [N*8-1:0]   hdr_o
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            b_q <= '0;
      else if (cap_i && idx_i == IDX_W'(g))   b_q <= data_i;
    end
    assign hdr_o[g*8 +: 8] = b_q;
  end
endmodule

// File: rtl/rx_byte_addr.sv
module rx_byte_addr #(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8,
  localparam int ADDR_W = PG_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PG_W-1:0]   start_pg_i,
  input  logic [PG_W-1:0]   stop_pg_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_inc, lim, span;

  assign addr_inc = addr_q + 1'b1;
  assign lim      = {stop_pg_i, {OFF_W{1'b0}}};
  assign span     = {stop_pg_i - start_pg_i, {OFF_W{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (inc_i)  addr_q <= (addr_inc >= lim) ? addr_inc - span : addr_inc;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int PG_W  = 8,
  parameter int OFF_W = 8,
  parameter int LEN_W = 16,
  localparam int ADDR_W = PG_W + OFF_W,
  localparam int CNT_W  = $clog2(HDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PG_W-1:0]   start_pg_i,
  input  logic [PG_W-1:0]   stop_pg_i,
  input  logic [LEN_W-1:0]  max_len_i,
  input  logic              cur_wr_i,
  input  logic [PG_W-1:0]   cur_pg_i,
  input  logic              ovf_set_i,
  input  logic              poll_i,
  input  logic              release_i,
  input  logic              byte_rd_i,
  output logic              ram_re_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [7:0]        ram_rdata_i,
  output logic              none_o,
  output logic              drop_o,
  output logic              frame_vld_o,
  output logic [LEN_W-1:0]  pay_len_o,
  output logic [ADDR_W-1:0] pay_addr_o,
  output logic              rd_vld_o,
  output logic [7:0]        rd_data_o,
  output logic [PG_W-1:0]   bnry_o,
  output logic [PG_W-1:0]   curr_o,
  output logic              ovf_o
);
  ring_st_e st_q;
  logic [CNT_W-1:0] iss_q, cap_q;
  logic             pend_q, none_q, drop_q, rd_vld_q;
  logic [LEN_W-1:0] pay_len_q, stored_len, pay_len;
  logic [HDR_BYTES*8-1:0] hdr;
  logic [PG_W-1:0]  rd_pg, nxt_pg;
  logic [ADDR_W-1:0] rd_addr;
  logic bnry_ok, empty, poll_go, rst_ptr, ovf_clr;
  logic hdr_re, byte_re, chk, nxt_ok, too_long, rel, cap_last;

  assign poll_go  = (st_q == ST_IDLE) && poll_i;
  assign rst_ptr  = poll_go && (ovf_o || !bnry_ok);
  assign ovf_clr  = poll_go && ovf_o;
  assign hdr_re   = (st_q == ST_HDR) && (iss_q < CNT_W'(HDR_BYTES));
  assign byte_re  = (st_q == ST_FRAME) && byte_rd_i;
  assign chk      = (st_q == ST_CHECK);
  assign cap_last = pend_q && (cap_q == CNT_W'(HDR_BYTES - 1));

  assign nxt_pg     = hdr[HDR_NEXT*8 +: 8];
  assign stored_len = {hdr[HDR_LEN_H*8 +: 8], hdr[HDR_LEN_L*8 +: 8]};
  assign pay_len    = stored_len - LEN_W'(HDR_BYTES);
  assign nxt_ok     = (nxt_pg >= start_pg_i) && (nxt_pg < stop_pg_i);
  assign too_long   = pay_len > max_len_i;
  assign rel        = byte_rel_frame() || (chk && nxt_ok && too_long);

  function automatic logic byte_rel_frame();
    return (st_q == ST_FRAME) && release_i;
  endfunction

  rx_ring_ptrs #(.PG_W(PG_W)) i_ptrs (
    .clk_i, .rst_ni, .start_pg_i, .stop_pg_i,
    .rst_ptr_i(rst_ptr), .rel_i(rel), .rel_nxt_i(nxt_pg),
    .cur_wr_i, .cur_pg_i, .ovf_set_i, .ovf_clr_i(ovf_clr),
    .bnry_o, .curr_o, .rd_pg_o(rd_pg), .ovf_o,
    .bnry_ok_o(bnry_ok), .empty_o(empty)
  );

  rx_hdr_capture #(.N(HDR_BYTES), .IDX_W(CNT_W)) i_hdr (
    .clk_i, .rst_ni, .cap_i(pend_q), .idx_i(cap_q),
    .data_i(ram_rdata_i), .hdr_o(hdr)
  );

  rx_byte_addr #(.PG_W(PG_W), .OFF_W(OFF_W)) i_addr (
    .clk_i, .rst_ni, .start_pg_i, .stop_pg_i,
    .load_i(chk), .load_addr_i(pay_addr_o), .inc_i(byte_re), .addr_o(rd_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      iss_q     <= '0;
      cap_q     <= '0;
      pend_q    <= 1'b0;
      none_q    <= 1'b0;
      drop_q    <= 1'b0;
      rd_vld_q  <= 1'b0;
      pay_len_q <= '0;
    end else begin
      none_q   <= (poll_go && (rst_ptr || empty)) || (chk && !nxt_ok);
      drop_q   <= chk && nxt_ok && too_long;
      rd_vld_q <= byte_re;
      pend_q   <= hdr_re;
      if (hdr_re) iss_q <= iss_q + 1'b1;
      if (pend_q) cap_q <= cap_q + 1'b1;
      unique case (st_q)
        ST_IDLE: if (poll_go && !rst_ptr && !empty) begin
          st_q  <= ST_HDR;
          iss_q <= '0;
          cap_q <= '0;
        end
        ST_HDR:   if (cap_last) st_q <= ST_CHECK;
        ST_CHECK: begin
          pay_len_q <= pay_len;
          st_q      <= (nxt_ok && !too_long) ? ST_FRAME : ST_IDLE;
        end
        ST_FRAME: if (release_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign ram_re_o    = hdr_re || byte_re;
  assign ram_addr_o  = hdr_re ? {rd_pg, OFF_W'(iss_q)} : rd_addr;
  assign pay_addr_o  = {rd_pg, OFF_W'(HDR_BYTES)};
  assign pay_len_o   = pay_len_q;
  assign frame_vld_o = (st_q == ST_FRAME);
  assign none_o      = none_q;
  assign drop_o      = drop_q;
  assign rd_vld_o    = rd_vld_q;
  assign rd_data_o   = ram_rdata_i;
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
  parameter int PG_W  = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PG_W-1:0]   start_pg_i,
  input logic [PG_W-1:0]   stop_pg_i,
  input logic              release_i,
  input logic              byte_rd_i,
  input logic              ram_re_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              none_o,
  input logic              drop_o,
  input logic              frame_vld_o,
  input logic              rd_vld_o,
  input logic [PG_W-1:0]   bnry_o,
  input logic [PG_W-1:0]   curr_o,
  input logic              ovf_o
);
  logic [2:0] hdr_rd_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              hdr_rd_cnt <= '0;
    else if (!frame_vld_o && ram_re_o)        hdr_rd_cnt <= hdr_rd_cnt + 1'b1;
    else if (none_o || drop_o || frame_vld_o) hdr_rd_cnt <= '0;
  end

  assert_ovf_recover_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> none_o && bnry_o == start_pg_i && curr_o == start_pg_i + 1'b1);

  assert_none_no_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    none_o |-> !$past(ram_re_o));

  assert_hdr_complete_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_vld_o) |-> hdr_rd_cnt == 3'd4);

  assert_drop_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !frame_vld_o && !none_o);

  assert_byte_follow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |-> $past(ram_re_o && frame_vld_o));

  assert_byte_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o && ram_re_o |-> ram_addr_o[ADDR_W-1 -: PG_W] >= start_pg_i
                             && ram_addr_o[ADDR_W-1 -: PG_W] < stop_pg_i);

  assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o && release_i |=> !frame_vld_o && bnry_o >= start_pg_i && bnry_o < stop_pg_i);

  assert_quiet_frame_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o && !byte_rd_i |-> !ram_re_o);
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PG_W(PG_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_pg_i(start_pg_i), .stop_pg_i(stop_pg_i),
  .release_i(release_i), .byte_rd_i(byte_rd_i), .ram_re_o(ram_re_o),
  .ram_addr_o(ram_addr_o), .none_o(none_o), .drop_o(drop_o),
  .frame_vld_o(frame_vld_o), .rd_vld_o(rd_vld_o), .bnry_o(bnry_o),
  .curr_o(curr_o), .ovf_o(ovf_o)
);

// File: tb/test_rx_ring_mgr.sv
module test_rx_ring_mgr;
  localparam int CLK_P = 10;
  localparam logic [7:0] START = 8'h10;
  localparam logic [7:0] STOP  = 8'h14;

  typedef struct packed {
    logic [7:0]  cur;
    logic [7:0]  nxt;
    logic [15:0] len;
    logic [1:0]  kind;  // 0 none, 1 frame, 2 drop
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{8'h12, 8'h12, 16'h0040, 2'd1},
    '{8'h13, 8'h13, 16'h0020, 2'd1},
    '{8'h13, 8'h11, 16'h0020, 2'd0},
    '{8'h10, 8'h10, 16'h0068, 2'd1},
    '{8'h12, 8'h11, 16'h0069, 2'd2},
    '{8'h13, 8'h20, 16'h0010, 2'd0},
    '{8'h13, 8'h12, 16'h0010, 2'd1}
  };

  logic clk = 0, rst_ni = 0;
  logic [7:0]  start_pg_i = START, stop_pg_i = STOP;
  logic [15:0] max_len_i = 16'd100;
  logic cur_wr_i = 0, ovf_set_i = 0, poll_i = 0, release_i = 0, byte_rd_i = 0;
  logic [7:0] cur_pg_i = 0;
  logic ram_re_o, none_o, drop_o, frame_vld_o, rd_vld_o, ovf_o;
  logic [15:0] ram_addr_o, pay_len_o, pay_addr_o;
  logic [7:0]  ram_rdata_i, rd_data_o, bnry_o, curr_o;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] hdr_mem [256];
  logic [3:0]  hdr_seen;
  logic [7:0]  m_bnry;

  always #(CLK_P/2) clk = ~clk;

  rx_ring_mgr i_rx_ring_mgr (
    .clk_i(clk), .rst_ni, .start_pg_i, .stop_pg_i, .max_len_i, .cur_wr_i, .cur_pg_i,
    .ovf_set_i, .poll_i, .release_i, .byte_rd_i, .ram_re_o, .ram_addr_o, .ram_rdata_i,
    .none_o, .drop_o, .frame_vld_o, .pay_len_o, .pay_addr_o, .rd_vld_o, .rd_data_o,
    .bnry_o, .curr_o, .ovf_o
  );

  function automatic logic [7:0] ram_fn(input logic [15:0] a);
    if (a[7:0] < 8'd4) return hdr_mem[a[15:8]][a[1:0]*8 +: 8];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (ram_re_o) begin
      ram_rdata_i <= ram_fn(ram_addr_o);
      if (ram_addr_o[7:0] < 8'd4) hdr_seen[ram_addr_o[1:0]] <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 frame, 2 drop, 3 timeout; lat in cycles from poll
  task automatic do_poll(output int kind, output int lat);
    hdr_seen = '0;
    poll_i = 1;
    @(negedge clk);
    poll_i = 0; cur_wr_i = 0;
    kind = 3; lat = 0;
    for (int k = 1; k <= 20; k++) begin
      if (none_o) begin kind = 0; lat = k; break; end
      if (drop_o) begin kind = 2; lat = k; break; end
      if (frame_vld_o) begin kind = 1; lat = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic set_cur(input logic [7:0] p);
    cur_wr_i = 1; cur_pg_i = p;
    @(negedge clk);
    cur_wr_i = 0;
  endtask

  task automatic pulse_release();
    release_i = 1;
    @(negedge clk);
    release_i = 0;
  endtask

  function automatic logic [7:0] rd_page(input logic [7:0] b);
    return (b + 9'd1 >= {1'b0, STOP}) ? START : b + 8'd1;
  endfunction

  function automatic logic [7:0] rel_page(input logic [7:0] n);
    return (n <= START) ? STOP - 8'd1 : n - 8'd1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int kind, lat;
    logic [7:0] rp;
    for (int i = 0; i < 256; i++) hdr_mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 bnry", bnry_o, 0);
    chk("R1 curr", curr_o, 0);
    chk("R1 flags", {ovf_o, frame_vld_o, none_o, drop_o, ram_re_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // R3: boundary 0 is outside the ring
    do_poll(kind, lat);
    chk("R3 none", kind, 0);
    chk("R3 bnry", bnry_o, START);
    chk("R3 curr", curr_o, START + 8'd1);
    m_bnry = START;

    for (int v = 0; v < NVEC; v++) begin
      rp = rd_page(m_bnry);
      hdr_mem[rp] = {VEC[v].len, VEC[v].nxt, 8'h01};
      set_cur(VEC[v].cur);
      do_poll(kind, lat);
      chk(VEC[v].kind == 1 ? "R5 outcome" : VEC[v].kind == 2 ? "R8 outcome" :
          (rp == VEC[v].cur ? "R4 outcome" : "R6 outcome"), kind, VEC[v].kind);
      if (VEC[v].kind == 1) begin
        chk("R5 latency", lat, 7);
        chk("R5 header reads", hdr_seen, 4'hF);
        chk("R7 length", pay_len_o, VEC[v].len - 16'd4);
        chk("R7 address", pay_addr_o, {rp, 8'h04});
        pulse_release();
        m_bnry = rel_page(VEC[v].nxt);
        chk("R10 bnry", bnry_o, m_bnry);
        chk("R10 vld low", frame_vld_o, 0);
      end else if (VEC[v].kind == 2) begin
        chk("R8 no frame", frame_vld_o, 0);
        m_bnry = rel_page(VEC[v].nxt);
        @(negedge clk);
        chk("R8 bnry", bnry_o, m_bnry);
      end else begin
        if (rp == VEC[v].cur) chk("R4 no reads", hdr_seen, 0);
        chk("R6 bnry kept", bnry_o, m_bnry);
      end
    end

    // R11: release and byte reads outside a frame
    pulse_release();
    chk("R11 bnry", bnry_o, m_bnry);
    byte_rd_i = 1; #1;
    chk("R11 no read", ram_re_o, 0);
    @(negedge clk); byte_rd_i = 0;

    // move boundary to 0x12 so the next frame sits in the last page
    max_len_i = 16'hFFFF;
    rp = rd_page(m_bnry);
    hdr_mem[rp] = {16'h0010, 8'h13, 8'h01};
    set_cur(8'h13);
    do_poll(kind, lat);
    pulse_release();
    m_bnry = rel_page(8'h13);
    chk("R10 bnry to 12", bnry_o, 8'h12);

    // R9: payload wrap from the last page back to start
    hdr_mem[8'h13] = {16'h0200, 8'h11, 8'h01};
    set_cur(8'h11);
    do_poll(kind, lat);
    chk("R9 frame", kind, 1);
    for (int i = 0; i < 253; i++) begin
      logic [15:0] ea;
      ea = (i < 252) ? 16'h1304 + 16'(i) : 16'h1000;
      byte_rd_i = 1; #1;
      if (i == 0 || i == 251 || i == 252) chk("R9 address", ram_addr_o, ea);
      @(negedge clk);
      if (i == 0 || i == 252) begin
        chk("R9 valid", rd_vld_o, 1);
        chk("R9 data", rd_data_o, ram_fn(ea));
      end
    end
    byte_rd_i = 0;

    // R12: write-page load in the same cycle as release
    release_i = 1; cur_wr_i = 1; cur_pg_i = 8'h12;
    @(negedge clk);
    release_i = 0; cur_wr_i = 0;
    chk("R12 bnry", bnry_o, 8'h10);
    chk("R12 curr", curr_o, 8'h12);

    // R2: overflow recovery, overriding a write-page load (R12)
    ovf_set_i = 1;
    @(negedge clk);
    ovf_set_i = 0;
    chk("R2 flag set", ovf_o, 1);
    cur_wr_i = 1; cur_pg_i = 8'h13;
    do_poll(kind, lat);
    chk("R2 none", kind, 0);
    chk("R2 no reads", hdr_seen, 0);
    chk("R2 flag clear", ovf_o, 0);
    chk("R2 bnry", bnry_o, START);
    chk("R12 curr overridden", curr_o, START + 8'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule